// File: doc/BRIEF.md
# Cascadable Serial Coefficient Loader

This block is the configuration port of one node in a network of coupled clock generators. A coefficient word arrives one bit at a time on a data line, paced by a slow serial clock. The bits collect in a shift register that the node never uses directly. When a shared update strobe rises, the whole word is copied at once into a holding register, and that register drives the node's filter gains. Between updates the node keeps running on the held word, so new coefficients can be shifted in while the loop stays closed. Every node in the network then switches to its new coefficients on the same strobe edge.

The shift register's most significant bit drives the node's serial output. That output feeds the data input of the next node, so one long chain of nodes needs only three shared lines: serial clock, serial data and update. For N chained nodes, the host sends N words back to back. The word for the farthest node goes first, most significant bit first.

The serial clock, data and update lines are asynchronous to the node clock. They are brought in through a synchronizer chain, and their rising edges are detected in the node clock domain. Each level of the serial clock must therefore last at least SYNC_STAGES+1 node clock cycles.

Top module: `cfg_chain_node`

## Requirements
- R1: The reset is synchronous and active-low. It clears the shift register and the holding register, so every coefficient output and sda_o read 0 after reset. Zero weights leave every filter input disconnected until the first update.
- R2: On each detected rising edge of sck_i, the register takes in sda_i. The result shows at the outputs SYNC_STAGES+1 clock edges after the input edge. Without an sck_i rising edge the shift register does not change.
- R3: The shift register moves towards its MSB, and the new bit enters at bit 0. sda_o is bit WORD_W-1. In a chain, the first bit sent therefore ends up as the MSB of the farthest node.
- R4: While bits are shifting, k1_o, k2_o and kw_o do not change. They change only after an update edge.
- R5: A rising edge of upd_i copies the complete shift register into the holding register, SYNC_STAGES+1 clock edges after the input edge. A high level of upd_i held for any length of time, and a falling edge, load nothing.
- R6: The held word is split into fields. k1_o is bits [24:20] (5 bits) and k2_o is bits [19:8] (12 bits). kw_o is bits [7:0] and packs four 2-bit input weights: weight 1 in [7:6], weight 2 in [5:4], weight 3 in [3:2], weight 4 in [1:0].
- R7: If sck_i and upd_i rise in the same cycle, the holding register takes the shift register contents from before that shift. The shift still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Shared serial clock, asynchronous |
| sda_i | input | 1 | Serial data from the previous node or the host |
| upd_i | input | 1 | Shared update strobe, asynchronous |
| sda_o | output | 1 | Serial data to the next node (shift register MSB) |
| k1_o | output | K1_W | Proportional gain field |
| k2_o | output | K2_W | Integral gain field |
| kw_o | output | NUM_IN*KW_W | Packed input weights, weight 1 in the top bits |

## Verification
The bench builds two nodes with the default parameters: a 25-bit word, two synchronizer stages, and the data output of the first node wired to the data input of the second. The serial clock uses half-periods of four node clocks. With two nodes chained, the bench can check the order of a 50-bit stream end to end, and a word moving from one node into the next. The short synchronizer keeps the latency of exactly three edges easy to observe. It also lets a serial-clock edge and an update edge coincide in one cycle.

// File: rtl/cfg_chain_pkg.sv
// Package: default field widths and synchronizer depth for the serial
// coefficient loader. Assumes each node holds one proportional field, one
// integral field and a fixed number of small input weights.
package cfg_chain_pkg;
    parameter int DEF_K1_W   = 5;
    parameter int DEF_K2_W   = 12;
    parameter int DEF_KW_W   = 2;
    parameter int DEF_NUM_IN = 4;
    parameter int DEF_SYNC   = 2;

    // Total word length for a given field layout.
    function automatic int word_width(input int k1_w, input int k2_w,
                                      input int kw_w, input int num_in);
        return k1_w + k2_w + kw_w * num_in;
    endfunction
endpackage

// File: rtl/cfg_sync_bus.sv
// Module: multi-bit synchronizer built from STAGES flop ranks.
// Assumes each bit is an independent slow level (no bus coherency needed)
// and STAGES >= 1.
module cfg_sync_bus #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_rank
        if (g == 0) begin : g_first
            // First rank samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Later ranks settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_rise_det.sv
// Module: rising-edge detector for already synchronized levels.
// Assumes the inputs are in the clk domain; the pulse lasts one cycle.
module cfg_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
// Module: serial-in parallel-out register, shifting towards the MSB.
// Assumes W >= 2; the MSB is the serial output to the next stage.
module cfg_shift_reg #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         ser_i,
    output logic [W-1:0] word_o,
    output logic         ser_o
);
    logic [W-1:0] sreg_q;

    // Take one bit in at position 0 on every shift enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg_q <= '0;
        else if (shift_en) sreg_q <= {sreg_q[W-2:0], ser_i};
    end

    assign word_o = sreg_q;
    assign ser_o  = sreg_q[W-1];
endmodule

// File: rtl/cfg_shadow_reg.sv
// Module: holding register loaded in parallel, plus field split.
// Assumes the layout MSB..LSB is K1, K2, then NUM_IN weights with weight 1
// highest.
module cfg_shadow_reg #(
    parameter int K1_W   = 5,
    parameter int K2_W   = 12,
    parameter int KW_W   = 2,
    parameter int NUM_IN = 4,
    localparam int KW_TOT = KW_W * NUM_IN,
    localparam int WORD_W = K1_W + K2_W + KW_TOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o,
    output logic [K1_W-1:0]   k1_o,
    output logic [K2_W-1:0]   k2_o,
    output logic [KW_TOT-1:0] kw_o
);
    logic [WORD_W-1:0] hold_q;

    // Copy the full word on a load pulse, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (load_en) hold_q <= word_i;
    end

    assign word_o = hold_q;
    assign k1_o   = hold_q[WORD_W-1 -: K1_W];
    assign k2_o   = hold_q[WORD_W-1-K1_W -: K2_W];

    // One slice per weight; weight index 0 (weight 1) sits highest.
    for (genvar g = 0; g < NUM_IN; g++) begin : g_wt
        assign kw_o[KW_TOT-1-g*KW_W -: KW_W] = hold_q[KW_TOT-1-g*KW_W -: KW_W];
    end
endmodule

// File: rtl/cfg_chain_node.sv
// Module: top of the per-node serial coefficient loader.
// Synchronizes sck/sda/upd into clk, shifts on sck rises, and loads the
// holding register on upd rises. Assumes each sck level lasts at least
// SYNC_STAGES+1 clk cycles.
module cfg_chain_node
    import cfg_chain_pkg::*;
#(
    parameter int K1_W        = DEF_K1_W,
    parameter int K2_W        = DEF_K2_W,
    parameter int KW_W        = DEF_KW_W,
    parameter int NUM_IN      = DEF_NUM_IN,
    parameter int SYNC_STAGES = DEF_SYNC,
    localparam int KW_TOT     = KW_W * NUM_IN,
    localparam int WORD_W     = word_width(K1_W, K2_W, KW_W, NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sda_i,
    input  logic              upd_i,
    output logic              sda_o,
    output logic [K1_W-1:0]   k1_o,
    output logic [K2_W-1:0]   k2_o,
    output logic [KW_TOT-1:0] kw_o
);
    logic [2:0]        sync_lvl;
    logic [1:0]        rise;
    logic              sck_rise;
    logic              upd_rise;
    logic [WORD_W-1:0] shift_word;
    logic [WORD_W-1:0] coef_word;

    cfg_sync_bus #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sck_i, sda_i, upd_i}),
        .sync_o  (sync_lvl)
    );

    cfg_rise_det #(.W(2)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({sync_lvl[2], sync_lvl[0]}),
        .rise_o  (rise)
    );

    assign sck_rise = rise[1];
    assign upd_rise = rise[0];

    cfg_shift_reg #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sck_rise),
        .ser_i    (sync_lvl[1]),
        .word_o   (shift_word),
        .ser_o    (sda_o)
    );

    cfg_shadow_reg #(.K1_W(K1_W), .K2_W(K2_W), .KW_W(KW_W), .NUM_IN(NUM_IN)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (upd_rise),
        .word_i  (shift_word),
        .word_o  (coef_word),
        .k1_o    (k1_o),
        .k2_o    (k2_o),
        .kw_o    (kw_o)
    );
endmodule

// File: rtl/cfg_chain_node_chk.sv
// Checker: temporal properties of the loader, bound into every node.
module cfg_chain_node_chk #(
    parameter int WORD_W = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck_rise,
    input logic              upd_rise,
    input logic [WORD_W-1:0] shift_word,
    input logic [WORD_W-1:0] coef_word,
    input logic              sda_o
);
    // R2: no serial clock edge, no change in the shift register
    p_sreg_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(shift_word));

    // R3: the serial output takes the bit just below the MSB on a shift
    p_sda_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> sda_o == $past(shift_word[WORD_W-2]));

    // R4: the held coefficients only move on an update edge
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_rise |=> $stable(coef_word));

    // R5 / R7: an update copies the pre-shift word
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_rise |=> coef_word == $past(shift_word));
endmodule

bind cfg_chain_node cfg_chain_node_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .upd_rise   (upd_rise),
    .shift_word (shift_word),
    .coef_word  (coef_word),
    .sda_o      (sda_o)
);

// File: tb/test_cfg_chain_node.sv
module test_cfg_chain_node;
    localparam int D = 2;   // synchronizer stages
    localparam int P = 4;   // sck half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sda = 1'b0, upd = 1'b0;
    logic        a_sda, b_sda;
    logic [4:0]  a_k1, b_k1;
    logic [11:0] a_k2, b_k2;
    logic [7:0]  a_kw, b_kw;

    int tests = 0, fails = 0;
    bit started = 0, done = 0;

    always #5 clk = ~clk;

    cfg_chain_node i_cfg_chain_node (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sda_i(sda), .upd_i(upd),
        .sda_o(a_sda), .k1_o(a_k1), .k2_o(a_k2), .kw_o(a_kw));

    cfg_chain_node i_cfg_chain_node_b (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sda_i(a_sda), .upd_i(upd),
        .sda_o(b_sda), .k1_o(b_k1), .k2_o(b_k2), .kw_o(b_kw));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit h_sck [0:D];
    bit h_upd [0:D];
    bit ha_sda [0:D];
    bit hb_sda [0:D];
    bit qa[$];
    bit qb[$];
    logic [24:0] sha = '0, shb = '0;
    bit sck_r, upd_r, b_in;

    function automatic logic [24:0] q2w(input bit q[$]);
        logic [24:0] w;
        for (int i = 0; i < 25; i++) w[24-i] = q[i];
        return w;
    endfunction

    initial begin
        for (int i = 0; i < 25; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
    end

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i <= D; i++) begin
                h_sck[i] = 0; h_upd[i] = 0; ha_sda[i] = 0; hb_sda[i] = 0;
            end
            qa = {}; qb = {};
            for (int i = 0; i < 25; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
            sha = '0; shb = '0;
        end else begin
            sck_r = h_sck[D-1] && !h_sck[D];
            upd_r = h_upd[D-1] && !h_upd[D];
            b_in  = qa[0];
            if (upd_r) begin sha = q2w(qa); shb = q2w(qb); end
            if (sck_r) begin
                void'(qa.pop_front()); qa.push_back(ha_sda[D-1]);
                void'(qb.pop_front()); qb.push_back(hb_sda[D-1]);
            end
            for (int i = D; i > 0; i--) begin
                h_sck[i] = h_sck[i-1]; h_upd[i] = h_upd[i-1];
                ha_sda[i] = ha_sda[i-1]; hb_sda[i] = hb_sda[i-1];
            end
            h_sck[0] = sck; h_upd[0] = upd; ha_sda[0] = sda; hb_sda[0] = b_in;
        end
    end

    // Cycle compare against the model (R3 serial out, R4/R5 held word).
    always @(negedge clk) begin
        if (started && !done) begin
            check("R4/R5 node A held word vs model", {7'd0, a_k1, a_k2, a_kw}, {7'd0, sha});
            check("R4/R5 node B held word vs model", {7'd0, b_k1, b_k2, b_kw}, {7'd0, shb});
            check("R3 node A sda_o vs model", {31'd0, a_sda}, {31'd0, qa[0]});
            check("R3 node B sda_o vs model", {31'd0, b_sda}, {31'd0, qb[0]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); sda = b; sck = 1'b0;
        idle(P - 1);
        @(negedge clk); sck = 1'b1;
        idle(P - 1);
    endtask

    task automatic send_word(input logic [24:0] w);
        for (int i = 24; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_upd();
        @(negedge clk); sck = 1'b0; upd = 1'b1;
        idle(P);
        upd = 1'b0;
        idle(P + D + 2);
    endtask

    task automatic check_a(input string req, input logic [24:0] exp);
        check(req, {7'd0, a_k1, a_k2, a_kw}, {7'd0, exp});
    endtask

    task automatic check_b(input string req, input logic [24:0] exp);
        check(req, {7'd0, b_k1, b_k2, b_kw}, {7'd0, exp});
    endtask

    localparam logic [24:0] WA = {5'h13, 12'hA5C, 8'h6C};
    localparam logic [24:0] WB = {5'h0A, 12'h3F1, 8'hE4};

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check_a("R1 A coefficients after reset", 25'd0);
        check_b("R1 B coefficients after reset", 25'd0);
        check("R1 sda_o after reset", {31'd0, a_sda}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R3/R4: farthest word first, MSB first; outputs stay put while shifting
        send_word(WB);
        check_a("R4 A unchanged mid-stream", 25'd0);
        send_word(WA);
        @(negedge clk); sck = 1'b0;
        idle(P + D + 2);
        check_a("R4 A unchanged before update", 25'd0);
        check_b("R4 B unchanged before update", 25'd0);
        check("R3 A sda_o is its MSB", {31'd0, a_sda}, {31'd0, WA[24]});
        check("R3 B sda_o is its MSB", {31'd0, b_sda}, {31'd0, WB[24]});

        // R5/R6: update loads both nodes at once, fields decoded
        pulse_upd();
        check("R6 A k1 field [24:20]", {27'd0, a_k1}, 32'h13);
        check("R6 A k2 field [19:8]", {20'd0, a_k2}, 32'hA5C);
        check("R6 A weight 1 in [7:6]", {30'd0, a_kw[7:6]}, 32'd1);
        check("R6 A weight 4 in [1:0]", {30'd0, a_kw[1:0]}, 32'd0);
        check_b("R3 B got first word sent", WB);

        // R5: high level held while shifting loads nothing; fall loads nothing
        @(negedge clk); upd = 1'b1;
        idle(P + D + 2);
        send_word(25'h1FFFFFF);
        @(negedge clk); sck = 1'b0;
        idle(P + D + 2);
        check_a("R5 held upd level does not reload A", WA);
        check_b("R5 held upd level does not reload B", WB);
        upd = 1'b0;
        idle(P + D + 2);
        check_a("R5 falling upd does not reload A", WA);
        pulse_upd();
        check_a("R5 A all-ones word loaded", 25'h1FFFFFF);
        check_b("R5 A word moved on into B", WA);

        // R7: sck and upd rise in the same cycle -> pre-shift word is held
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        @(negedge clk); sck = 1'b0;
        idle(P + D + 2);
        @(negedge clk); sda = 1'b0; sck = 1'b1; upd = 1'b1;
        idle(P + D + 2);
        sck = 1'b0; upd = 1'b0;
        idle(P + D + 2);
        check_a("R7 A holds pre-shift word", 25'h1FFFFF8);
        check_b("R7 B holds pre-shift word", {WA[21:0], 3'b111});

        // R1: reset in mid-operation clears everything
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check_a("R1 A cleared by reset", 25'd0);
        check_b("R1 B cleared by reset", 25'd0);
        check("R1 B sda_o cleared by reset", {31'd0, b_sda}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2/R5: exact latency of SYNC_STAGES+1 edges
        send_word(25'h1FFFFFF);
        @(negedge clk); sck = 1'b0;
        idle(P + D + 2);
        check("R2 ones reached A MSB", {31'd0, a_sda}, 32'd1);
        @(negedge clk); upd = 1'b1;     // before edge k
        @(negedge clk);                 // after edge k
        @(negedge clk);                 // after edge k+1
        check("R5 no load after two edges", {27'd0, a_k1}, 32'd0);
        @(negedge clk);                 // after edge k+2
        check("R5 load after three edges", {27'd0, a_k1}, 32'h1F);
        check_b("R2 B received A's zeros", 25'd0);
        upd = 1'b0;
        idle(P + D + 2);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule